// File: doc/BRIEF.md
# Shared Event Counter Bank

A bank of event counters that belongs to the whole multi-core package rather than to any one core. It is built from a parameterized number of boxes. Each box has four general counters and one counter that only counts clock cycles. Every general counter has a control word. The control word picks one of the box's event lanes by its event code, turns counting on, and can require that the lane's match field equal a programmed filter value. Event lanes deliver a 4-bit increment every cycle. Any single increment counts as at most 8.

Some event classes are tied to particular counters. If such an event is programmed into a counter that may not take it, that counter stays idle. When any counter in any box wraps, a global control unit records which box wrapped. If freezing is enabled, it stops every counter in the bank and raises one interrupt line toward a selectable core. Software reaches every register through one flat write/read address bus, which any core may drive.

Top module: `shared_evt_ctr_bank`

## Requirements
- R1: After reset every counter, every control word and the global register read as zero, and no interrupt line is high.
- R2: A general counter whose control bit 0 (enable) is set adds, at each clock, the increment of the lane named by event code bits [2:0]. The event code sits in control bits [15:8]. An increment above 8 counts as 8.
- R3: An event code whose bits [7:6] are 01 (occupancy class) counts only on counter 0. Bits [7:6] equal to 10 (ring class) count only on counters 2 and 3. Such a code in any other counter leaves that counter unchanged. Class codes 00 and 11 count on any counter.
- R4: With control bit 1 (filter enable) set, a counter adds a lane's increment only in cycles where that lane's match field equals control bits [23:16].
- R5: The cycle counter (register 4) adds one per clock while bit 0 of its control register (register 12) is set, and holds its value while that bit is clear.
- R6: Counters are CTR_W bits wide (48 by default, 44 also supported) and wrap modulo 2^CTR_W. At the clock edge where a counter in box b wraps, global status bit 16+b is set.
- R7: With global bit 0 (freeze enable) set, a wrap sets global bit 1 (frozen) at the same edge. From the next edge on, no counter changes except through a register write. Software writes bit 1 to freeze or unfreeze. A wrap takes priority over a write of 0 to bit 1 in the same cycle.
- R8: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. A wrap in the same cycle as a clear leaves the bit set.
- R9: Interrupt line c is high exactly while freeze enable is set, some status bit is set, and global bits [9:8] hold c. At most one line is high.
- R10: A register write to a counter sets it to the written value even when an increment arrives in the same cycle. Counting resumes from that value at the next edge.
- R11: The global register is at address 0x80. Box b occupies addresses b*16 to b*16+15: registers 0-3 are the general counters, 4 is the cycle counter, 8-11 are the control words and 12 is the cycle-counter control. Reads are combinational, and unused addresses read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write address |
| wr_data | input | 64 | Register write data |
| rd_addr | input | 8 | Register read address |
| rd_data | output | 64 | Register read data (combinational) |
| evt_inc | input | NUM_BOXES*NUM_LANES*4 | Per-lane increment, box-major, 4 bits per lane |
| evt_match | input | NUM_BOXES*NUM_LANES*8 | Per-lane match field, box-major, 8 bits per lane |
| irq | output | NUM_CORES | One interrupt line per core |

## Verification
Two pairs of functions can fall in the same cycle, and the bench forces both. The first pair is a bus write to a counter while its selected lane carries an increment. The bench holds the lane at 5, writes 100, and expects exactly 100 after the write edge and 105 one edge later. The second pair is a wrap together with a write that clears status and freeze. The bench loads a counter with its maximum value, then drives a single increment of 1 in the same cycle as the clearing write. It expects the status bit set, the frozen bit set, the counter at zero and the interrupt on the target core.

// File: rtl/evb_pkg.sv
package evb_pkg;
  localparam int INC_W    = 4;
  localparam int INC_MAX  = 8;
  localparam int EVT_W    = 8;
  localparam int MATCH_W  = 8;
  localparam int NUM_GEN  = 4;
  localparam int DATA_W   = 64;
  localparam int ADDR_W   = 8;
  localparam int REG_W    = 4;
  localparam int FIX_REG  = NUM_GEN;
  localparam int CTL_BASE = 8;
  localparam int FIX_CTL  = 12;
  localparam int GLB_TGT  = 8;
  localparam int GLB_STS  = 16;

  typedef enum logic [1:0] {
    CLS_ANY_LO = 2'b00,
    CLS_OCC    = 2'b01,
    CLS_RING   = 2'b10,
    CLS_ANY_HI = 2'b11
  } evt_class_e;

  typedef struct packed {
    logic [MATCH_W-1:0] flt;
    logic [EVT_W-1:0]   code;
    logic [5:0]         rsv;
    logic               flt_en;
    logic               en;
  } ctl_t;

  // saturate one cycle's contribution of a lane
  function automatic logic [INC_W-1:0] clip_inc(logic [INC_W-1:0] raw);
    return (raw > INC_W'(INC_MAX)) ? INC_W'(INC_MAX) : raw;
  endfunction

  // counter/event-class constraint table
  function automatic logic evt_allowed(logic [EVT_W-1:0] code, int idx);
    case (evt_class_e'(code[EVT_W-1 -: 2]))
      CLS_OCC:  return idx == 0;
      CLS_RING: return (idx == 2) || (idx == 3);
      default:  return 1'b1;
    endcase
  endfunction

  function automatic ctl_t word_to_ctl(logic [DATA_W-1:0] w);
    ctl_t c;
    c        = ctl_t'(w[$bits(ctl_t)-1:0]);
    c.rsv    = '0;
    return c;
  endfunction
endpackage

// File: rtl/evb_counter.sv
module evb_counter
  import evb_pkg::*;
#(
  parameter int CTR_W = 48
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld,
  input  logic [CTR_W-1:0] ld_val,
  input  logic [INC_W-1:0] add,
  output logic [CTR_W-1:0] cnt,
  output logic             wrap
);
  function automatic logic [CTR_W:0] sum_ext(logic [CTR_W-1:0] a, logic [INC_W-1:0] b);
    return {1'b0, a} + (CTR_W+1)'(b);
  endfunction

  logic [CTR_W:0] sum;
  assign sum  = sum_ext(cnt, add);
  assign wrap = !ld && sum[CTR_W];

  always_ff @(posedge clk) begin
    if (!rst_n)  cnt <= '0;
    else if (ld) cnt <= ld_val;
    else         cnt <= sum[CTR_W-1:0];
  end
endmodule

// File: rtl/evb_box.sv
module evb_box
  import evb_pkg::*;
#(
  parameter int CTR_W     = 48,
  parameter int NUM_LANES = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         frozen,
  input  logic                         wr_en,
  input  logic [REG_W-1:0]             wr_reg,
  input  logic [DATA_W-1:0]            wr_data,
  input  logic [REG_W-1:0]             rd_reg,
  output logic [DATA_W-1:0]            rd_data,
  input  logic [NUM_LANES*INC_W-1:0]   lane_inc,
  input  logic [NUM_LANES*MATCH_W-1:0] lane_match,
  output logic                         ovf_any,
  output logic [(NUM_GEN+1)*CTR_W-1:0] cnt_flat
);
  localparam int LANE_W = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1;

  logic [CTR_W-1:0] cnt_arr [NUM_GEN+1];
  ctl_t             ctl_arr [NUM_GEN];
  logic [NUM_GEN:0] wraps;
  logic             fix_en_q;

  for (genvar g = 0; g < NUM_GEN; g++) begin : g_gen
    logic [LANE_W-1:0]  lane_sel;
    logic [INC_W-1:0]   raw, add;
    logic [MATCH_W-1:0] mt;
    logic               hit;

    always_ff @(posedge clk) begin
      if (!rst_n) ctl_arr[g] <= '0;
      else if (wr_en && wr_reg == REG_W'(CTL_BASE + g)) ctl_arr[g] <= word_to_ctl(wr_data);
    end

    assign lane_sel = ctl_arr[g].code[LANE_W-1:0];
    assign raw      = lane_inc[int'(lane_sel)*INC_W +: INC_W];
    assign mt       = lane_match[int'(lane_sel)*MATCH_W +: MATCH_W];
    assign hit      = ctl_arr[g].en && !frozen && evt_allowed(ctl_arr[g].code, g)
                      && (!ctl_arr[g].flt_en || mt == ctl_arr[g].flt);
    assign add      = hit ? clip_inc(raw) : '0;

    evb_counter #(.CTR_W(CTR_W)) u_ctr (
      .clk(clk), .rst_n(rst_n),
      .ld(wr_en && wr_reg == REG_W'(g)), .ld_val(wr_data[CTR_W-1:0]),
      .add(add), .cnt(cnt_arr[g]), .wrap(wraps[g])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) fix_en_q <= 1'b0;
    else if (wr_en && wr_reg == REG_W'(FIX_CTL)) fix_en_q <= wr_data[0];
  end

  evb_counter #(.CTR_W(CTR_W)) u_fix (
    .clk(clk), .rst_n(rst_n),
    .ld(wr_en && wr_reg == REG_W'(FIX_REG)), .ld_val(wr_data[CTR_W-1:0]),
    .add((fix_en_q && !frozen) ? INC_W'(1) : INC_W'(0)),
    .cnt(cnt_arr[NUM_GEN]), .wrap(wraps[NUM_GEN])
  );

  assign ovf_any = |wraps;

  for (genvar k = 0; k <= NUM_GEN; k++) begin : g_flat
    assign cnt_flat[k*CTR_W +: CTR_W] = cnt_arr[k];
  end

  always_comb begin
    rd_data = '0;
    for (int k = 0; k <= NUM_GEN; k++)
      if (rd_reg == REG_W'(k)) rd_data = DATA_W'(cnt_arr[k]);
    for (int k = 0; k < NUM_GEN; k++)
      if (rd_reg == REG_W'(CTL_BASE + k)) rd_data = DATA_W'(ctl_arr[k]);
    if (rd_reg == REG_W'(FIX_CTL)) rd_data = DATA_W'(fix_en_q);
  end
endmodule

// File: rtl/evb_global.sv
module evb_global
  import evb_pkg::*;
#(
  parameter int NUM_BOXES = 2,
  parameter int NUM_CORES = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [DATA_W-1:0]    wr_data,
  input  logic [NUM_BOXES-1:0] box_ovf,
  output logic                 freeze_en,
  output logic                 frozen,
  output logic [NUM_BOXES-1:0] status,
  output logic [NUM_CORES-1:0] irq,
  output logic [DATA_W-1:0]    rd_data
);
  localparam int TGT_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1;

  logic [TGT_W-1:0] tgt_q;

  // clear-on-one first, then new wraps win
  function automatic logic [NUM_BOXES-1:0] next_status(
      logic [NUM_BOXES-1:0] cur, logic wr, logic [DATA_W-1:0] d, logic [NUM_BOXES-1:0] set);
    logic [NUM_BOXES-1:0] v;
    v = wr ? (cur & ~d[GLB_STS +: NUM_BOXES]) : cur;
    return v | set;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      freeze_en <= 1'b0;
      frozen    <= 1'b0;
      tgt_q     <= '0;
      status    <= '0;
    end else begin
      if (wr_en) begin
        freeze_en <= wr_data[0];
        tgt_q     <= wr_data[GLB_TGT +: TGT_W];
      end
      status <= next_status(status, wr_en, wr_data, box_ovf);
      if (freeze_en && (|box_ovf)) frozen <= 1'b1;
      else if (wr_en)              frozen <= wr_data[1];
    end
  end

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_irq
    assign irq[c] = freeze_en && (|status) && (tgt_q == TGT_W'(c));
  end

  always_comb begin
    rd_data                       = '0;
    rd_data[0]                    = freeze_en;
    rd_data[1]                    = frozen;
    rd_data[GLB_TGT +: TGT_W]     = tgt_q;
    rd_data[GLB_STS +: NUM_BOXES] = status;
  end
endmodule

// File: rtl/shared_evt_ctr_bank.sv
module shared_evt_ctr_bank
  import evb_pkg::*;
#(
  parameter int CTR_W     = 48,
  parameter int NUM_BOXES = 2,
  parameter int NUM_LANES = 8,
  parameter int NUM_CORES = 4
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   wr_en,
  input  logic [ADDR_W-1:0]                      wr_addr,
  input  logic [DATA_W-1:0]                      wr_data,
  input  logic [ADDR_W-1:0]                      rd_addr,
  output logic [DATA_W-1:0]                      rd_data,
  input  logic [NUM_BOXES*NUM_LANES*INC_W-1:0]   evt_inc,
  input  logic [NUM_BOXES*NUM_LANES*MATCH_W-1:0] evt_match,
  output logic [NUM_CORES-1:0]                   irq
);
  localparam int BOX_CNT_W = (NUM_GEN + 1) * CTR_W;
  localparam int ALL_W     = NUM_BOXES * BOX_CNT_W;
  localparam int BOXID_W   = ADDR_W - 1 - REG_W;

  // named internal events for the checker
  logic [NUM_BOXES-1:0] box_ovf;
  logic [NUM_BOXES-1:0] status;
  logic                 frozen;
  logic                 freeze_en;
  logic [ALL_W-1:0]     all_cnt;

  logic [DATA_W-1:0] box_rd [NUM_BOXES];
  logic [DATA_W-1:0] glb_rd;

  for (genvar b = 0; b < NUM_BOXES; b++) begin : g_box
    evb_box #(.CTR_W(CTR_W), .NUM_LANES(NUM_LANES)) u_box (
      .clk(clk), .rst_n(rst_n), .frozen(frozen),
      .wr_en(wr_en && !wr_addr[ADDR_W-1] && wr_addr[REG_W +: BOXID_W] == BOXID_W'(b)),
      .wr_reg(wr_addr[REG_W-1:0]), .wr_data(wr_data),
      .rd_reg(rd_addr[REG_W-1:0]), .rd_data(box_rd[b]),
      .lane_inc(evt_inc[b*NUM_LANES*INC_W +: NUM_LANES*INC_W]),
      .lane_match(evt_match[b*NUM_LANES*MATCH_W +: NUM_LANES*MATCH_W]),
      .ovf_any(box_ovf[b]),
      .cnt_flat(all_cnt[b*BOX_CNT_W +: BOX_CNT_W])
    );
  end

  evb_global #(.NUM_BOXES(NUM_BOXES), .NUM_CORES(NUM_CORES)) u_glb (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en && wr_addr[ADDR_W-1] && wr_addr[ADDR_W-2:0] == '0),
    .wr_data(wr_data), .box_ovf(box_ovf),
    .freeze_en(freeze_en), .frozen(frozen), .status(status),
    .irq(irq), .rd_data(glb_rd)
  );

  always_comb begin
    rd_data = '0;
    if (rd_addr[ADDR_W-1]) begin
      if (rd_addr[ADDR_W-2:0] == '0) rd_data = glb_rd;
    end else begin
      for (int b = 0; b < NUM_BOXES; b++)
        if (rd_addr[REG_W +: BOXID_W] == BOXID_W'(b)) rd_data = box_rd[b];
    end
  end
endmodule

// File: rtl/evb_checker.sv
module evb_checker #(
  parameter int NUM_BOXES = 2,
  parameter int NUM_CORES = 4,
  parameter int CNT_BITS  = 480
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 wr_en,
  input logic                 frozen,
  input logic                 freeze_en,
  input logic [NUM_BOXES-1:0] box_ovf,
  input logic [NUM_BOXES-1:0] status,
  input logic [NUM_CORES-1:0] irq,
  input logic [CNT_BITS-1:0]  all_cnt
);
  assert_status_on_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (box_ovf != '0) |=> ((status & $past(box_ovf)) == $past(box_ovf)));

  assert_freeze_on_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze_en && box_ovf != '0) |=> frozen);

  assert_frozen_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (frozen && !wr_en) |=> $stable(all_cnt));

  assert_status_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ((status & $past(status)) == $past(status)));

  assert_irq_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(irq));

  assert_irq_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq != '0) |-> (freeze_en && status != '0));
endmodule

bind shared_evt_ctr_bank evb_checker #(
  .NUM_BOXES(NUM_BOXES), .NUM_CORES(NUM_CORES), .CNT_BITS(ALL_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .frozen(frozen), .freeze_en(freeze_en),
  .box_ovf(box_ovf), .status(status), .irq(irq), .all_cnt(all_cnt)
);

// File: tb/shared_evt_ctr_bank_tb.sv
`timescale 1ns/1ps
module shared_evt_ctr_bank_tb;
  localparam int CW = 48;
  localparam int NB = 2;
  localparam int NL = 8;
  localparam int NC = 4;
  localparam logic [63:0] CMAX = (64'd1 << CW) - 64'd1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [7:0] wr_addr = '0, rd_addr = '0;
  logic [63:0] wr_data = '0;
  logic [63:0] rd_data;
  logic [NB*NL*4-1:0] evt_inc = '0;
  logic [NB*NL*8-1:0] evt_match = '0;
  logic [NC-1:0] irq;

  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  shared_evt_ctr_bank #(.CTR_W(CW), .NUM_BOXES(NB), .NUM_LANES(NL), .NUM_CORES(NC)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .evt_inc(evt_inc), .evt_match(evt_match), .irq(irq)
  );

  function automatic logic [7:0] adr(int b, int r);
    return 8'((b << 4) | r);
  endfunction

  // bench restatement of the counting rules
  function automatic int bm_add(logic [7:0] code, int k, bit en, bit fe, logic [7:0] fv,
                                int inc, logic [7:0] m);
    bit legal;
    if (code[7:6] == 2'b01)      legal = (k == 0);
    else if (code[7:6] == 2'b10) legal = (k >= 2);
    else                         legal = 1'b1;
    if (!en || !legal || (fe && m != fv)) return 0;
    return (inc > 8) ? 8 : inc;
  endfunction

  task automatic check(string what, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", what, got, exp);
    end
  endtask

  task automatic rd(logic [7:0] a, output logic [63:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic bus_wr(logic [7:0] a, logic [63:0] d);
    @(negedge clk);
    wr_addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_inc(int b, int l, logic [3:0] v);
    evt_inc[(b*NL + l)*4 +: 4] = v;
  endtask

  task automatic set_match(int b, int l, logic [7:0] v);
    evt_match[(b*NL + l)*8 +: 8] = v;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; wr_en = 1'b0; evt_inc = '0; evt_match = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog all requirements got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] v, v2;
    logic [7:0] rcode [4];
    logic [7:0] rfv [4];
    bit ren [4], rfe [4];
    longint model [4];
    void'($urandom(32'h5EED_0042));

    // R1 reset state
    do_reset();
    rd(adr(0,0), v);  check("R1 ctr0", v, 0);
    rd(adr(1,4), v);  check("R1 cycle ctr", v, 0);
    rd(adr(0,8), v);  check("R1 ctl0", v, 0);
    rd(adr(1,12), v); check("R1 cycle ctl", v, 0);
    rd(8'h80, v);     check("R1 global", v, 0);
    check("R1 irq", 64'(irq), 0);

    // R11 control readback and unused address
    bus_wr(adr(1,9), 64'h0033_0503);
    rd(adr(1,9), v); check("R11 ctl readback", v, 64'h0033_0503);
    rd(adr(0,5), v); check("R11 unused reads zero", v, 0);

    // R2 lane select and clipping
    do_reset();
    bus_wr(adr(0,8), 64'h0000_0201);
    set_inc(0,2,4'd5); repeat (3) @(negedge clk);
    set_inc(0,2,4'd0);
    rd(adr(0,0), v); check("R2 three cycles of 5", v, 15);
    set_inc(0,2,4'd15); @(negedge clk);
    set_inc(0,2,4'd9);  @(negedge clk);
    set_inc(0,2,4'd0);
    rd(adr(0,0), v); check("R2 clip 15 and 9 to 8", v, 31);

    // R10 write beats increment
    set_inc(0,2,4'd5);
    bus_wr(adr(0,0), 64'd100);
    rd(adr(0,0), v); check("R10 write wins over increment", v, 100);
    @(negedge clk);
    rd(adr(0,0), v); check("R10 counting resumes", v, 105);

    // R7 software freeze / unfreeze
    bus_wr(8'h80, 64'h2);
    rd(8'h80, v); check("R7 sw frozen bit", v, 64'h2);
    rd(adr(0,0), v);
    repeat (3) @(negedge clk);
    rd(adr(0,0), v2); check("R7 sw freeze holds", v2, v);
    bus_wr(8'h80, 64'h0);
    rd(adr(0,0), v);
    @(negedge clk);
    rd(adr(0,0), v2); check("R7 unfreeze resumes", v2, v + 5);
    set_inc(0,2,4'd0);

    // R3 constraints, round A
    do_reset();
    bus_wr(adr(0,8),  64'h0000_4101);
    bus_wr(adr(0,9),  64'h0000_4101);
    bus_wr(adr(0,10), 64'h0000_4101);
    bus_wr(adr(0,11), 64'h0000_8101);
    set_inc(0,1,4'd3); repeat (4) @(negedge clk); set_inc(0,1,4'd0);
    rd(adr(0,0), v); check("R3 occupancy on ctr0", v, 12);
    rd(adr(0,1), v); check("R3 occupancy on ctr1 idle", v, 0);
    rd(adr(0,2), v); check("R3 occupancy on ctr2 idle", v, 0);
    rd(adr(0,3), v); check("R3 ring on ctr3", v, 12);
    // round B
    do_reset();
    bus_wr(adr(0,8),  64'h0000_8101);
    bus_wr(adr(0,9),  64'h0000_8101);
    bus_wr(adr(0,10), 64'h0000_8101);
    set_inc(0,1,4'd3); repeat (4) @(negedge clk); set_inc(0,1,4'd0);
    rd(adr(0,0), v); check("R3 ring on ctr0 idle", v, 0);
    rd(adr(0,1), v); check("R3 ring on ctr1 idle", v, 0);
    rd(adr(0,2), v); check("R3 ring on ctr2", v, 12);

    // R4 filter
    do_reset();
    bus_wr(adr(0,8), 64'h005A_0003);
    set_inc(0,0,4'd4); set_match(0,0,8'h5A); @(negedge clk);
    set_match(0,0,8'h11); @(negedge clk);
    set_inc(0,0,4'd2); set_match(0,0,8'h5A); @(negedge clk);
    set_inc(0,0,4'd0);
    rd(adr(0,0), v); check("R4 filter match only", v, 6);

    // R5 cycle counter
    bus_wr(adr(0,12), 64'h1);
    rd(adr(0,4), v);
    repeat (10) @(negedge clk);
    rd(adr(0,4), v2); check("R5 cycle count over 10", v2 - v, 10);
    bus_wr(adr(0,12), 64'h0);
    rd(adr(0,4), v);
    repeat (5) @(negedge clk);
    rd(adr(0,4), v2); check("R5 disabled holds", v2, v);

    // constrained random on box 1 (R2 R3 R4)
    do_reset();
    for (int k = 0; k < 4; k++) begin
      rcode[k] = {2'($urandom_range(3)), 3'b000, 3'($urandom_range(7))};
      ren[k]   = ($urandom_range(7) != 0);
      rfe[k]   = 1'($urandom_range(1));
      rfv[k]   = 8'($urandom_range(3));
      model[k] = 0;
      bus_wr(adr(1, 8+k), {40'd0, rfv[k], rcode[k], 6'd0, rfe[k], ren[k]});
    end
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      for (int l = 0; l < NL; l++) begin
        set_inc(1, l, 4'($urandom_range(15)));
        set_match(1, l, 8'($urandom_range(3)));
      end
      for (int k = 0; k < 4; k++) begin
        int ln;
        ln = int'(rcode[k][2:0]);
        model[k] += bm_add(rcode[k], k, ren[k], rfe[k], rfv[k],
                           int'(evt_inc[(NL + ln)*4 +: 4]), evt_match[(NL + ln)*8 +: 8]);
      end
    end
    @(negedge clk);
    evt_inc = '0; evt_match = '0;
    for (int k = 0; k < 4; k++) begin
      rd(adr(1,k), v);
      check($sformatf("R2 R3 R4 random ctr%0d", k), v, 64'(model[k]));
    end

    // R6 R7 R9 wrap, freeze, interrupt
    do_reset();
    bus_wr(8'h80, 64'h0000_0201);
    bus_wr(adr(0,8), 64'h0000_0001);
    bus_wr(adr(1,1), CMAX - 64'd2);
    bus_wr(adr(1,9), 64'h0000_0001);
    set_inc(0,0,4'd1);
    @(negedge clk);
    set_inc(1,0,4'd5); @(negedge clk); @(negedge clk);
    set_inc(1,0,4'd0);
    rd(adr(1,1), v); check("R6 wrap modulo", v, 2);
    rd(8'h80, v); check("R6 R7 status and frozen", v, 64'h0002_0203);
    check("R9 irq to core 2", 64'(irq), 64'h4);
    rd(adr(0,0), v);
    repeat (3) @(negedge clk);
    rd(adr(0,0), v2); check("R7 other box frozen", v2, v);

    // R8 clear
    bus_wr(8'h80, 64'h0002_0201);
    rd(8'h80, v); check("R8 status cleared", v, 64'h0000_0201);
    check("R9 irq drops", 64'(irq), 0);
    bus_wr(adr(1,1), CMAX);
    // wrap in the same cycle as a clear
    @(negedge clk);
    wr_addr = 8'h80; wr_data = 64'h0002_0201; wr_en = 1'b1;
    set_inc(1,0,4'd1);
    @(negedge clk);
    wr_en = 1'b0; set_inc(1,0,4'd0);
    rd(8'h80, v); check("R8 R7 wrap beats clear", v, 64'h0002_0203);
    rd(adr(1,1), v); check("R6 wrap from max", v, 0);
    check("R9 irq again", 64'(irq), 64'h4);
    bus_wr(8'h80, 64'h0002_0000);
    rd(8'h80, v); check("R8 final clear", v, 0);
    check("R9 irq off without enable", 64'(irq), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule